// File: doc/BRIEF.md
# Shared GPIO Port Line Resolver

This block models a 16-pin general-purpose port whose pins can be driven both by the CPU and by up to four external peripheral agents. The CPU sets up the port through a register bus. One 32-bit control word holds, for every pin, an output-enable bit and a pull-up bit. A 16-bit data register holds the value the CPU drives. Each agent supplies its own per-pin drive enables and data. The block ORs three terms to form the resolved level of each pin: CPU drive, agent drive, and a pull-up that applies only when nothing drives the pin.

Every accepted register write is compared against the levels it displaces. One cycle later the block presents the new levels, the set of pins that toggled, and a one-cycle notification pulse. The pulse goes to each agent whose 16-bit trigger mask overlaps the toggled pins. Reading the data register returns the resolved levels rather than the stored CPU value.

Top module: `gpio_port_resolver`

## Requirements
- R1: In the control word (address 1'b0 of the 2-bit bus address, i.e. 2'd0), bit 2n is the CPU output enable of pin n and bit 2n+1 is the pull-up enable of pin n. A control read returns the stored word unchanged.
- R2: A pin with its CPU output enable set is high whenever the CPU data register bit (address 2'd1, bits 15:0) is 1.
- R3: A pin is high when any agent a has agent_oe_i[16a+n] and agent_data_i[16a+n] both set.
- R4: The pull-up drives a pin high only when neither the CPU nor any agent enables a driver on that pin. A pin that is driven low, or that has no driver and no pull-up, reads 0.
- R5: A read (bus_valid_i=1, bus_write_i=0) is combinational. Address 2'd1 returns the resolved levels in bits 15:0 with zeros above. When no read is in progress, bus_rdata_o is 0.
- R6: After a write to address 2'd0 or 2'd1, on the next clock edge change_o becomes the XOR of the levels before and after the write. On the same edge, level_o becomes the new levels. Any set notify_o bit lasts one cycle.
- R7: A write that leaves the resolved levels unchanged raises no notify_o bit, and change_o becomes 0.
- R8: Agent a's notify_o bit rises only if agent_mask_i[16a +: 16] AND the changed pins is nonzero.
- R9: After reset, the control word and data register are 0. With agent drives at 0, every pin reads 0, and notify_o, change_o and level_o are 0.
- R10: A write to address 2'd2 or 2'd3 changes no state and raises no notification. Reads of those addresses return 0.
- R11: A change of agent inputs without a register write updates pins_o but never raises notify_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register select: 0 control, 1 data |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data |
| agent_oe_i | input | 64 | Per-agent pin drive enables, 16 bits per agent |
| agent_data_i | input | 64 | Per-agent pin drive values, 16 bits per agent |
| agent_mask_i | input | 64 | Per-agent trigger masks, 16 bits per agent |
| pins_o | output | 16 | Current resolved pin levels |
| notify_o | output | 4 | One-cycle per-agent change pulse |
| change_o | output | 16 | Pins toggled by the last register write |
| level_o | output | 16 | Resolved levels just after the last register write |

## Verification
The bench targets several cases that a flawed resolver would get wrong:
- Pull-up masking: a pin whose pull-up sits under an agent driving 0 must read 0. A resolver that ORs the pull-up in unconditionally reads 1.
- Interleaved decode: a swapped or shifted split of the control word shows up as wrong levels under half-word control patterns.
- Quiet writes: a write of the same value, or of data under a disabled driver, must raise no pulse. An edge detector that fires on every write fails this case.
- Mask overlap: some agents' masks miss the toggled pins while others hit them, which exposes a broadcast notification.
- Agent-only changes and unmapped writes: the bench checks that both are silent.

// File: rtl/gpio_res_pkg.sv
package gpio_res_pkg;
  localparam int REG_ADDR_W = 2;
  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_DATA = 2'd1;
endpackage

// File: rtl/gpio_ctrl_decode.sv
module gpio_ctrl_decode #(
  parameter int NUM_PINS = 16,
  localparam int CTRL_W = 2 * NUM_PINS
) (
  input  logic [CTRL_W-1:0]   ctrl_i,
  output logic [NUM_PINS-1:0] oe_o,
  output logic [NUM_PINS-1:0] pu_o
);
  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    assign oe_o[n] = ctrl_i[2*n];
    assign pu_o[n] = ctrl_i[2*n+1];
  end
endmodule

// File: rtl/gpio_line_resolve.sv
module gpio_line_resolve #(
  parameter int NUM_PINS   = 16,
  parameter int NUM_AGENTS = 4,
  localparam int AG_W = NUM_PINS * NUM_AGENTS
) (
  input  logic [NUM_PINS-1:0] cpu_oe_i,
  input  logic [NUM_PINS-1:0] cpu_pu_i,
  input  logic [NUM_PINS-1:0] cpu_data_i,
  input  logic [AG_W-1:0]     ag_oe_i,
  input  logic [AG_W-1:0]     ag_data_i,
  output logic [NUM_PINS-1:0] lvl_o
);
  logic [NUM_PINS-1:0] ag_drv [NUM_AGENTS+1];
  logic [NUM_PINS-1:0] ag_en  [NUM_AGENTS+1];

  assign ag_drv[0] = '0;
  assign ag_en[0]  = '0;
  for (genvar a = 0; a < NUM_AGENTS; a++) begin : g_ag
    assign ag_drv[a+1] = ag_drv[a] | (ag_oe_i[a*NUM_PINS +: NUM_PINS] & ag_data_i[a*NUM_PINS +: NUM_PINS]);
    assign ag_en[a+1]  = ag_en[a]  |  ag_oe_i[a*NUM_PINS +: NUM_PINS];
  end

  assign lvl_o = (cpu_oe_i & cpu_data_i)
               | ag_drv[NUM_AGENTS]
               | (cpu_pu_i & ~(cpu_oe_i | ag_en[NUM_AGENTS]));
endmodule

// File: rtl/gpio_change_notify.sv
module gpio_change_notify #(
  parameter int NUM_PINS   = 16,
  parameter int NUM_AGENTS = 4,
  localparam int AG_W = NUM_PINS * NUM_AGENTS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [NUM_PINS-1:0]   old_i,
  input  logic [NUM_PINS-1:0]   new_i,
  input  logic [AG_W-1:0]       mask_i,
  output logic [NUM_AGENTS-1:0] notify_o,
  output logic [NUM_PINS-1:0]   change_o,
  output logic [NUM_PINS-1:0]   level_o
);
  logic [NUM_PINS-1:0]   diff;
  logic [NUM_AGENTS-1:0] hit;

  assign diff = old_i ^ new_i;
  for (genvar a = 0; a < NUM_AGENTS; a++) begin : g_hit
    assign hit[a] = |(mask_i[a*NUM_PINS +: NUM_PINS] & diff);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      notify_o <= '0;
      change_o <= '0;
      level_o  <= '0;
    end else begin
      notify_o <= wr_i ? hit : '0;
      if (wr_i) begin
        change_o <= diff;
        level_o  <= new_i;
      end
    end
  end

  // R7: a pulse always comes with a nonzero toggle set
  p_no_pulse_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|notify_o) |-> (|change_o));

  for (genvar a = 0; a < NUM_AGENTS; a++) begin : g_chk
    // R8: pulse only where the agent's mask saw a toggle
    p_notify_masked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      notify_o[a] |-> (|($past(mask_i[a*NUM_PINS +: NUM_PINS]) & change_o)));
  end
endmodule

// File: rtl/gpio_port_resolver.sv
module gpio_port_resolver
  import gpio_res_pkg::*;
#(
  parameter int NUM_PINS   = 16,
  parameter int NUM_AGENTS = 4,
  localparam int CTRL_W = 2 * NUM_PINS,
  localparam int AG_W   = NUM_PINS * NUM_AGENTS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_valid_i,
  input  logic                  bus_write_i,
  input  logic [REG_ADDR_W-1:0] bus_addr_i,
  input  logic [CTRL_W-1:0]     bus_wdata_i,
  output logic [CTRL_W-1:0]     bus_rdata_o,
  input  logic [AG_W-1:0]       agent_oe_i,
  input  logic [AG_W-1:0]       agent_data_i,
  input  logic [AG_W-1:0]       agent_mask_i,
  output logic [NUM_PINS-1:0]   pins_o,
  output logic [NUM_AGENTS-1:0] notify_o,
  output logic [NUM_PINS-1:0]   change_o,
  output logic [NUM_PINS-1:0]   level_o
);
  logic [CTRL_W-1:0]   ctrl_q, ctrl_d;
  logic [NUM_PINS-1:0] data_q, data_d;
  logic                ctrl_wr, data_wr, reg_wr;
  logic [NUM_PINS-1:0] oe_cur, pu_cur, oe_nxt, pu_nxt, lvl_nxt;

  assign ctrl_wr = bus_valid_i && bus_write_i && (bus_addr_i == ADDR_CTRL);
  assign data_wr = bus_valid_i && bus_write_i && (bus_addr_i == ADDR_DATA);
  assign reg_wr  = ctrl_wr || data_wr;
  assign ctrl_d  = ctrl_wr ? bus_wdata_i : ctrl_q;
  assign data_d  = data_wr ? bus_wdata_i[NUM_PINS-1:0] : data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      data_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      data_q <= data_d;
    end
  end

  gpio_ctrl_decode #(.NUM_PINS(NUM_PINS)) u_dec_cur (
    .ctrl_i(ctrl_q), .oe_o(oe_cur), .pu_o(pu_cur));
  gpio_ctrl_decode #(.NUM_PINS(NUM_PINS)) u_dec_nxt (
    .ctrl_i(ctrl_d), .oe_o(oe_nxt), .pu_o(pu_nxt));

  gpio_line_resolve #(.NUM_PINS(NUM_PINS), .NUM_AGENTS(NUM_AGENTS)) u_res_cur (
    .cpu_oe_i(oe_cur), .cpu_pu_i(pu_cur), .cpu_data_i(data_q),
    .ag_oe_i(agent_oe_i), .ag_data_i(agent_data_i), .lvl_o(pins_o));
  gpio_line_resolve #(.NUM_PINS(NUM_PINS), .NUM_AGENTS(NUM_AGENTS)) u_res_nxt (
    .cpu_oe_i(oe_nxt), .cpu_pu_i(pu_nxt), .cpu_data_i(data_d),
    .ag_oe_i(agent_oe_i), .ag_data_i(agent_data_i), .lvl_o(lvl_nxt));

  gpio_change_notify #(.NUM_PINS(NUM_PINS), .NUM_AGENTS(NUM_AGENTS)) u_notify (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(reg_wr),
    .old_i(pins_o), .new_i(lvl_nxt), .mask_i(agent_mask_i),
    .notify_o(notify_o), .change_o(change_o), .level_o(level_o));

  always_comb begin
    bus_rdata_o = '0;
    if (bus_valid_i && !bus_write_i) begin
      unique case (bus_addr_i)
        ADDR_CTRL: bus_rdata_o = ctrl_q;
        ADDR_DATA: bus_rdata_o = CTRL_W'(pins_o);
        default:   bus_rdata_o = '0;
      endcase
    end
  end

  // R6: pulses only follow an accepted register write
  p_pulse_after_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|notify_o) |-> $past(reg_wr));
  // R11: no write, no pulse on the next cycle
  p_quiet_without_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_wr |=> (notify_o == '0));
  // R6: reported level matches the pins while agent drive holds still
  p_level_tracks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr |=> (!$stable(agent_oe_i) || !$stable(agent_data_i) || (level_o == pins_o)));
  // R10: unmapped writes leave the control word alone
  p_unmapped_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_write_i && bus_addr_i[1]) |=> $stable(ctrl_q));
endmodule

// File: tb/gpio_port_resolver_bench.sv
module gpio_port_resolver_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, write = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] ag_oe = '0, ag_data = '0, ag_mask = '0;
  logic [15:0] pins, change, level;
  logic [3:0]  notify;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  gpio_port_resolver u_gpio_port_resolver (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_write_i(write),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .agent_oe_i(ag_oe), .agent_data_i(ag_data), .agent_mask_i(ag_mask),
    .pins_o(pins), .notify_o(notify), .change_o(change), .level_o(level));

  // {ctrl, cpu data, agent1 oe, agent1 data, expected pins}
  localparam logic [95:0] VEC [9] = '{
    {32'h0000_0000, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000},
    {32'h5555_5555, 16'hA5C3, 16'h0000, 16'h0000, 16'hA5C3},
    {32'hAAAA_AAAA, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF},
    {32'hAAAA_AAAA, 16'h0000, 16'h00FF, 16'h000F, 16'hFF0F},
    {32'h0000_FFFF, 16'h1234, 16'h0000, 16'h0000, 16'h0034},
    {32'hFFFF_0000, 16'h00F0, 16'h000F, 16'h0005, 16'h0005},
    {32'h0000_0002, 16'h0000, 16'h0001, 16'h0000, 16'h0000},
    {32'h0000_0003, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
    {32'h0000_0001, 16'h0000, 16'h0001, 16'h0001, 16'h0001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; write = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; write = 1'b0; addr = a;
    #1 d = rdata;
    valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 pins", {16'h0, pins}, 32'h0);
    check("R9 notify", {28'h0, notify}, 32'h0);
    check("R9 level", {16'h0, level}, 32'h0);
    rst_n = 1'b1;
    bus_rd(2'd0, rd); check("R9 ctrl", rd, 32'h0);

    // R1 R2 R3 R4 R5: vector walk
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      ag_oe   = {32'h0, VEC[i][47:32], 16'h0};
      ag_data = {32'h0, VEC[i][31:16], 16'h0};
      bus_wr(2'd0, VEC[i][95:64]);
      bus_wr(2'd1, {16'h0, VEC[i][63:48]});
      check("R2 R3 R4 pins", {16'h0, pins}, {16'h0, VEC[i][15:0]});
      bus_rd(2'd1, rd); check("R5 data read", rd, {16'h0, VEC[i][15:0]});
      bus_rd(2'd0, rd); check("R1 ctrl read", rd, VEC[i][95:64]);
    end

    // notification section
    @(negedge clk);
    ag_oe = '0; ag_data = '0;
    ag_mask = {16'h0000, 16'hFFFF, 16'h0002, 16'h0001};
    bus_wr(2'd0, 32'h5555_5555);
    bus_wr(2'd1, 32'h0);
    bus_wr(2'd1, 32'h1);
    check("R8 notify a0 a2", {28'h0, notify}, 32'h5);
    check("R6 change", {16'h0, change}, 32'h1);
    check("R6 level", {16'h0, level}, 32'h1);
    @(negedge clk);
    check("R6 pulse ends", {28'h0, notify}, 32'h0);
    bus_wr(2'd1, 32'h3);
    check("R8 notify a1 a2", {28'h0, notify}, 32'h6);
    check("R6 change bit1", {16'h0, change}, 32'h2);
    bus_wr(2'd1, 32'h3);
    check("R7 same value", {28'h0, notify}, 32'h0);
    check("R7 change zero", {16'h0, change}, 32'h0);
    bus_wr(2'd0, 32'h0);
    check("R6 ctrl write notify", {28'h0, notify}, 32'h7);
    check("R6 ctrl write change", {16'h0, change}, 32'h3);
    check("R6 ctrl write level", {16'h0, level}, 32'h0);
    bus_wr(2'd1, 32'hFFFF);
    check("R7 undriven data", {28'h0, notify}, 32'h0);

    // R11 agent-only change
    @(negedge clk);
    ag_oe = 64'h1; ag_data = 64'h1;
    @(negedge clk);
    check("R11 pins follow agent", {16'h0, pins}, 32'h1);
    check("R11 no notify", {28'h0, notify}, 32'h0);
    @(negedge clk);
    check("R11 no notify later", {28'h0, notify}, 32'h0);

    // R10 unmapped
    bus_wr(2'd2, 32'h5555_5555);
    check("R10 no notify", {28'h0, notify}, 32'h0);
    bus_rd(2'd0, rd); check("R10 ctrl kept", rd, 32'h0);
    check("R10 pins kept", {16'h0, pins}, 32'h1);
    bus_rd(2'd3, rd); check("R10 read zero", rd, 32'h0);
    @(negedge clk);
    check("R5 idle rdata", rdata, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule